// File: doc/BRIEF.md
# Turbo Frequency Step Controller

This block picks the operating frequency of one processor core. It holds a step index above a nominal operating point and presents two registered outputs: a multiplier ratio code and the matching frequency in MHz. With boosting enabled, each pulse of a step tick can raise the index by one fixed 133 MHz increment. Any rise needs the thermal-headroom flag to report that the chip's envelope is respected.

Two rules limit how far the index may climb. The first is the number of idle cores elsewhere on the die: the limit is twice the idle count, capped at the top step. The second is the thermal flag. When it drops, each tick takes one step back toward nominal. When the idle count falls below the current step, the index is cut back on the next clock and does not wait for a tick.

Clock generation, temperature sensing and voltage control sit outside this block. They appear only as the input flags.

Top module: `turbo_step_ctrl`

## Requirements
- R1: While the synchronous active-high reset is high, the next clock puts the step index at 0, so freq_mhz reads 2700 and ratio_code reads 20.
- R2: While enable is low, the next clock returns the index to 0 (2700 MHz, ratio 20). Step ticks, the thermal flag and the idle count have no effect.
- R3: For step index k, ratio_code equals 20 + k. freq_mhz equals 2700 + 133*k for k from 0 to 6, and exactly 3700 for the top step k = 7. freq_mhz never exceeds 3700.
- R4: When enabled, with thermal_ok high, a tick pulse, and an index below the limit, the index rises by exactly one on the next clock. Without a tick the index never rises.
- R5: When enabled, with thermal_ok low and a tick pulse, the index falls by one on the next clock. At 0 it stays at 0. It never rises while thermal_ok is low.
- R6: The limit is min(7, 2*idle_cores). If the index is above the limit, the next clock sets it to the limit, whether or not a tick is present.
- R7: When the index equals the limit and thermal_ok is high, a tick leaves the index unchanged.
- R8: Priority runs from disable, to the over-limit cut, to the tick action. A tick in the same cycle as an over-limit cut moves the index only to the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Boosting permitted; low forces nominal |
| thermal_ok | input | 1 | High while the thermal envelope has headroom |
| step_tick | input | 1 | One-cycle pulse allowing one step change |
| idle_cores | input | IDLE_W (4) | Number of other cores currently idle |
| ratio_code | output | RATIO_W (6) | Multiplier code, 20 + step index |
| freq_mhz | output | FREQ_W (13) | Current core frequency in MHz |

## Verification
The bench climbs the ladder all the way to the top step. A design that reports 2700 + 7*133 there, rather than clamping to 3700, would show 3631. It then lowers the idle count with no tick present. A design that waits for a tick before cutting back would hold the index above the new limit. It also applies ticks with the thermal flag low at step 0, where an unguarded decrement would wrap to the top step, and sends a tick at the same time as an over-limit cut, where stacking the two actions would land one step below the limit. Finally it leaves enable low while ticks keep arriving, which exposes any design that lets a tick raise the frequency while boosting is off.

// File: rtl/turbo_pkg.sv
package turbo_pkg;

  typedef enum logic [2:0] {
    ACT_HOLD  = 3'd0,
    ACT_UP    = 3'd1,
    ACT_DOWN  = 3'd2,
    ACT_CLAMP = 3'd3,
    ACT_HOME  = 3'd4
  } step_act_e;

endpackage

// File: rtl/turbo_limit.sv
module turbo_limit #(
  parameter int IDLE_W    = 4,
  parameter int IDLE_GAIN = 2,
  parameter int MAX_STEP  = 7,
  parameter int IDX_W     = 3
) (
  input  logic [IDLE_W-1:0] idle_cores,
  output logic [IDX_W-1:0]  limit
);
  localparam int GAIN_W = $clog2(IDLE_GAIN + 1);
  localparam int SCL_W  = IDLE_W + GAIN_W;

  logic [SCL_W-1:0] scaled;

  always_comb begin
    scaled = SCL_W'(idle_cores) * SCL_W'(IDLE_GAIN);
    if (scaled > SCL_W'(MAX_STEP)) limit = IDX_W'(MAX_STEP);
    else                           limit = scaled[IDX_W-1:0];
  end
endmodule

// File: rtl/turbo_step_decide.sv
module turbo_step_decide
  import turbo_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             enable,
  input  logic             thermal_ok,
  input  logic             step_tick,
  input  logic [IDX_W-1:0] idx,
  input  logic [IDX_W-1:0] limit,
  output step_act_e        act,
  output logic [IDX_W-1:0] idx_next
);
  always_comb begin
    act = ACT_HOLD;
    if (!enable)             act = ACT_HOME;
    else if (idx > limit)    act = ACT_CLAMP;
    else if (step_tick) begin
      if (!thermal_ok) begin
        if (idx != '0)       act = ACT_DOWN;
      end else if (idx < limit) begin
        act = ACT_UP;
      end
    end
  end

  always_comb begin
    unique case (act)
      ACT_HOME:  idx_next = '0;
      ACT_CLAMP: idx_next = limit;
      ACT_UP:    idx_next = idx + IDX_W'(1);
      ACT_DOWN:  idx_next = idx - IDX_W'(1);
      default:   idx_next = idx;
    endcase
  end
endmodule

// File: rtl/turbo_freq_map.sv
module turbo_freq_map #(
  parameter int IDX_W       = 3,
  parameter int MAX_STEP    = 7,
  parameter int NOMINAL_MHZ = 2700,
  parameter int STEP_MHZ    = 133,
  parameter int CEIL_MHZ    = 3700,
  parameter int BASE_RATIO  = 20,
  parameter int FREQ_W      = 13,
  parameter int RATIO_W     = 6
) (
  input  logic [IDX_W-1:0]   idx,
  output logic [FREQ_W-1:0]  freq,
  output logic [RATIO_W-1:0] ratio
);
  logic [FREQ_W-1:0] raw;

  always_comb begin
    raw = FREQ_W'(NOMINAL_MHZ) + FREQ_W'(STEP_MHZ) * FREQ_W'(idx);
    if (idx >= IDX_W'(MAX_STEP) || raw > FREQ_W'(CEIL_MHZ))
      freq = FREQ_W'(CEIL_MHZ);
    else
      freq = raw;
    ratio = RATIO_W'(BASE_RATIO) + RATIO_W'(idx);
  end
endmodule

// File: rtl/turbo_step_ctrl.sv
module turbo_step_ctrl
  import turbo_pkg::*;
#(
  parameter int IDLE_W      = 4,
  parameter int IDLE_GAIN   = 2,
  parameter int MAX_STEP    = 7,
  parameter int NOMINAL_MHZ = 2700,
  parameter int STEP_MHZ    = 133,
  parameter int CEIL_MHZ    = 3700,
  parameter int BASE_RATIO  = 20,
  parameter int FREQ_W      = 13,
  parameter int RATIO_W     = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic               thermal_ok,
  input  logic               step_tick,
  input  logic [IDLE_W-1:0]  idle_cores,
  output logic [RATIO_W-1:0] ratio_code,
  output logic [FREQ_W-1:0]  freq_mhz
);
  localparam int IDX_W = $clog2(MAX_STEP + 1);

  logic [IDX_W-1:0]   idx_q;
  logic [IDX_W-1:0]   idx_d;
  logic [IDX_W-1:0]   limit;
  step_act_e          act;
  logic [FREQ_W-1:0]  freq_d;
  logic [RATIO_W-1:0] ratio_d;

  turbo_limit #(
    .IDLE_W(IDLE_W), .IDLE_GAIN(IDLE_GAIN), .MAX_STEP(MAX_STEP), .IDX_W(IDX_W)
  ) u_limit (
    .idle_cores(idle_cores),
    .limit     (limit)
  );

  turbo_step_decide #(.IDX_W(IDX_W)) u_decide (
    .enable    (enable),
    .thermal_ok(thermal_ok),
    .step_tick (step_tick),
    .idx       (idx_q),
    .limit     (limit),
    .act       (act),
    .idx_next  (idx_d)
  );

  turbo_freq_map #(
    .IDX_W(IDX_W), .MAX_STEP(MAX_STEP), .NOMINAL_MHZ(NOMINAL_MHZ),
    .STEP_MHZ(STEP_MHZ), .CEIL_MHZ(CEIL_MHZ), .BASE_RATIO(BASE_RATIO),
    .FREQ_W(FREQ_W), .RATIO_W(RATIO_W)
  ) u_map (
    .idx  (idx_d),
    .freq (freq_d),
    .ratio(ratio_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q      <= '0;
      freq_mhz   <= FREQ_W'(NOMINAL_MHZ);
      ratio_code <= RATIO_W'(BASE_RATIO);
    end else begin
      idx_q      <= idx_d;
      freq_mhz   <= freq_d;
      ratio_code <= ratio_d;
    end
  end
endmodule

// File: rtl/turbo_step_ctrl_chk.sv
module turbo_step_ctrl_chk #(
  parameter int IDLE_W      = 4,
  parameter int IDLE_GAIN   = 2,
  parameter int MAX_STEP    = 7,
  parameter int NOMINAL_MHZ = 2700,
  parameter int CEIL_MHZ    = 3700,
  parameter int BASE_RATIO  = 20,
  parameter int FREQ_W      = 13,
  parameter int RATIO_W     = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               enable,
  input logic               thermal_ok,
  input logic               step_tick,
  input logic [IDLE_W-1:0]  idle_cores,
  input logic [RATIO_W-1:0] ratio_code,
  input logic [FREQ_W-1:0]  freq_mhz
);
  logic [RATIO_W-1:0] cap_ratio;

  always_comb begin
    if (int'(idle_cores) * IDLE_GAIN > MAX_STEP)
      cap_ratio = RATIO_W'(BASE_RATIO + MAX_STEP);
    else
      cap_ratio = RATIO_W'(BASE_RATIO + int'(idle_cores) * IDLE_GAIN);
  end

  AST_DISABLED_NOMINAL: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (freq_mhz == FREQ_W'(NOMINAL_MHZ) && ratio_code == RATIO_W'(BASE_RATIO))); // R2

  AST_FREQ_CEILING: assert property (@(posedge clk) disable iff (rst)
    freq_mhz <= FREQ_W'(CEIL_MHZ)); // R3

  AST_ONE_STEP_UP: assert property (@(posedge clk) disable iff (rst)
    (ratio_code > $past(ratio_code)) |->
      (ratio_code == $past(ratio_code) + RATIO_W'(1) && $past(step_tick) && $past(enable))); // R4

  AST_HOT_NO_RISE: assert property (@(posedge clk) disable iff (rst)
    !thermal_ok |=> ratio_code <= $past(ratio_code)); // R5

  AST_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ratio_code <= $past(cap_ratio)); // R6
endmodule

bind turbo_step_ctrl turbo_step_ctrl_chk #(
  .IDLE_W(IDLE_W), .IDLE_GAIN(IDLE_GAIN), .MAX_STEP(MAX_STEP),
  .NOMINAL_MHZ(NOMINAL_MHZ), .CEIL_MHZ(CEIL_MHZ), .BASE_RATIO(BASE_RATIO),
  .FREQ_W(FREQ_W), .RATIO_W(RATIO_W)
) u_chk (
  .clk(clk), .rst(rst), .enable(enable), .thermal_ok(thermal_ok),
  .step_tick(step_tick), .idle_cores(idle_cores),
  .ratio_code(ratio_code), .freq_mhz(freq_mhz)
);

// File: tb/turbo_step_ctrl_bench.sv
`timescale 1ns/1ps
module turbo_step_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable = 1'b0;
  logic       thermal_ok = 1'b0;
  logic       step_tick = 1'b0;
  logic [3:0] idle_cores = 4'd0;
  logic [5:0] ratio_code;
  logic [12:0] freq_mhz;

  typedef struct {
    int    freq;
    int    ratio;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   failures = 0;
  int   m_idx = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  turbo_step_ctrl u_turbo_step_ctrl (
    .clk(clk), .rst(rst), .enable(enable), .thermal_ok(thermal_ok),
    .step_tick(step_tick), .idle_cores(idle_cores),
    .ratio_code(ratio_code), .freq_mhz(freq_mhz)
  );

  function automatic int freq_of(int k);
    return (k == 7) ? 3700 : 2700 + 133 * k;
  endfunction

  task automatic apply(bit r, bit en_i, bit tok_i, int idle_i, bit tick_i, string tag);
    int lim;
    exp_t e;
    @(negedge clk);
    rst        = r;
    enable     = en_i;
    thermal_ok = tok_i;
    idle_cores = idle_i[3:0];
    step_tick  = tick_i;
    lim = (2 * idle_i > 7) ? 7 : 2 * idle_i;
    if (r || !en_i)      m_idx = 0;
    else if (m_idx > lim) m_idx = lim;
    else if (tick_i) begin
      if (!tok_i) begin
        if (m_idx > 0) m_idx = m_idx - 1;
      end else if (m_idx < lim) begin
        m_idx = m_idx + 1;
      end
    end
    e.freq  = freq_of(m_idx);
    e.ratio = 20 + m_idx;
    e.tag   = tag;
    exp_q.push_back(e);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (int'(freq_mhz) != e.freq || int'(ratio_code) != e.ratio) begin
          failures++;
          $display("FAIL %s freq=%0d ratio=%0d expected freq=%0d ratio=%0d",
                   e.tag, freq_mhz, ratio_code, e.freq, e.ratio);
        end
      end
    end
  end

  initial begin
    apply(1, 0, 0, 0, 0, "R1");
    apply(1, 1, 1, 4, 1, "R1");
    // climb to the top with idle limit 7; idle cycles between ticks
    for (int i = 0; i < 7; i++) begin
      apply(0, 1, 1, 4, 1, "R4/R3");
      apply(0, 1, 1, 4, 0, "R4");
    end
    apply(0, 1, 1, 4, 1, "R7");
    apply(0, 1, 1, 15, 1, "R3");
    // idle drop cuts back without tick
    apply(0, 1, 1, 2, 0, "R6");
    apply(0, 1, 1, 2, 0, "R6");
    // hot: step down to zero and stay
    for (int i = 0; i < 5; i++) begin
      apply(0, 1, 0, 2, 1, "R5");
      apply(0, 1, 0, 2, 0, "R5");
    end
    // limit 2 and hold at it
    for (int i = 0; i < 3; i++) apply(0, 1, 1, 1, 1, "R7");
    // clamp together with a tick
    apply(0, 1, 1, 0, 1, "R8");
    apply(0, 1, 0, 0, 1, "R5");
    // climb to 6 on limit 6
    for (int i = 0; i < 7; i++) apply(0, 1, 1, 3, 1, "R3/R4");
    // idle 2 cut with a hot tick at the same time
    apply(0, 1, 0, 2, 1, "R8");
    apply(0, 1, 1, 3, 1, "R4");
    // disable overrides ticks
    apply(0, 0, 1, 4, 1, "R2/R8");
    for (int i = 0; i < 3; i++) apply(0, 0, 1, 4, 1, "R2");
    apply(0, 1, 1, 4, 1, "R4");
    apply(0, 1, 1, 4, 1, "R4");
    apply(1, 1, 1, 4, 1, "R1");
    apply(0, 1, 1, 4, 0, "R1");
    @(posedge clk);
    #2;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired: actual hung, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule